// File: doc/BRIEF.md
# Timed-Unlock Clock Control Register

This block is an 8-bit control register for the clock management logic. It sits behind a simple CPU write/read port. Its configuration fields are guarded by an unlock bit. Those fields are the external clock input choice, the clock source choice, the monitor enable, the slow oscillator disable and a two-bit mode. Software first writes an unlock pattern. That opens a short window of a fixed number of cycles, four by default. One write of configuration data inside the window updates every guarded field in one cycle and closes the window. If the window times out with no such write, it closes on its own.

The clock monitor can force the clock source choice back to the internal source at any time through a failure strobe. The strobe wins over a software write in the same cycle. The external input choice can only change while the internal source is selected. The read port returns the register contents at once. Bit 6 always reads as zero.

Top module: `ckc_ctrl_reg`

## Requirements
- R1: The register layout is bit 7 unlock, bit 6 reserved, bit 5 external input select (0 = input 0, 1 = input 1), bit 4 clock source select, bit 3 monitor enable, bit 2 slow oscillator disable, and bits 1:0 mode. Bit 6 reads as zero whatever is written to it.
- R2: After a synchronous reset every bit reads zero and every field output is zero.
- R3: The unlock bit is set only by an accepted write of exactly 0x80, meaning bit 7 is one and all other bits are zero. An accepted write is one where the write strobe and address match are both high. A write with bit 7 set and any other bit set does not unlock.
- R4: The unlock bit reads one for exactly four cycles after the write that sets it, then clears. A configuration write in the last of those cycles is still accepted.
- R5: An accepted write other than 0x80 while unlocked clears the unlock bit on the next cycle.
- R6: Writing 0x80 again while unlocked changes nothing. The window is not restarted, not cleared and not shortened, and no field is updated.
- R7: While locked, writes to the guarded fields are ignored. A write without address match is ignored in every state.
- R8: A write while unlocked loads mode, slow oscillator disable, monitor enable and clock source select from the data in one cycle. It loads external input select only if clock source select was zero before the write.
- R9: The failure strobe clears clock source select on the next cycle in any unlock state. It overrides a same-cycle write of one to that bit, while the other fields of that write still load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Bus write strobe |
| addr_hit | input | 1 | Address matches this register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Register read value |
| mon_fail | input | 1 | Clock monitor failure strobe |
| unlocked | output | 1 | Change window open |
| ext_in_sel | output | 1 | External clock input choice |
| src_sel | output | 1 | Clock source choice (1 = external) |
| mon_en | output | 1 | Clock monitor enable |
| slow_osc_off | output | 1 | Slow oscillator disable |
| clk_mode | output | 2 | Clock mode field |

## Verification
A wrong window counter shows up on rdata bit 7. It stays high a cycle too long or too short. Or a rewrite of the unlock pattern moves the point where it falls. Either way the error appears within five cycles of the unlock write. A wrong accept condition in the field registers shows up on the cycle after the write. A locked write, a bad pattern, or an input change under the external source then changes the read value. The failure-strobe priority is visible on bit 4 on the cycle after a strobe that coincides with a write.

// File: rtl/ckc_pkg.sv
package ckc_pkg;

    localparam logic [7:0] UNLOCK_PATTERN = 8'h80;

    localparam int BIT_UNLOCK  = 7;
    localparam int BIT_RSV     = 6;
    localparam int BIT_EXT_SEL = 5;
    localparam int BIT_SRC_SEL = 4;
    localparam int BIT_MON_EN  = 3;
    localparam int BIT_SLOW    = 2;

    typedef struct packed {
        logic       ext_sel;
        logic       src_sel;
        logic       mon_en;
        logic       slow_off;
        logic [1:0] mode;
    } ckc_cfg_t;

    function automatic logic is_unlock(input logic [7:0] d);
        return d == UNLOCK_PATTERN;
    endfunction

    function automatic ckc_cfg_t unpack_cfg(input logic [7:0] d);
        ckc_cfg_t c;
        c.ext_sel  = d[BIT_EXT_SEL];
        c.src_sel  = d[BIT_SRC_SEL];
        c.mon_en   = d[BIT_MON_EN];
        c.slow_off = d[BIT_SLOW];
        c.mode     = d[1:0];
        return c;
    endfunction

    function automatic logic [7:0] pack_reg(input logic open, input ckc_cfg_t c);
        return {open, 1'b0, c.ext_sel, c.src_sel, c.mon_en, c.slow_off, c.mode};
    endfunction

endpackage

// File: rtl/ckc_window.sv
module ckc_window #(
    parameter int WIN_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic unlock_req,
    input  logic close_req,
    output logic open_o
);
    localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic          open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cnt    <= '0;
        end else if (!open_q) begin
            if (unlock_req) begin
                open_q <= 1'b1;
                cnt    <= CNT_LOAD;
            end
        end else if (close_req || cnt == '0) begin
            open_q <= 1'b0;
            cnt    <= '0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign open_o = open_q;

    AST_WIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        open_q && !close_req && cnt != '0 |=> open_q); // R4
    AST_WIN_EXPIRES: assert property (@(posedge clk) disable iff (rst)
        open_q && cnt == '0 |=> !open_q); // R4
    AST_WIN_CLOSE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        open_q && close_req |=> !open_q); // R5
    AST_WIN_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        open_q && unlock_req && cnt != '0 |=> cnt == $past(cnt) - 1'b1); // R6

endmodule

// File: rtl/ckc_fields.sv
module ckc_fields
    import ckc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    input  logic [7:0] wdata,
    input  logic       fail,
    output ckc_cfg_t   cfg_o
);
    ckc_cfg_t cfg_q;
    ckc_cfg_t wr_cfg;

    assign wr_cfg = unpack_cfg(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (take) begin
                cfg_q.mode     <= wr_cfg.mode;
                cfg_q.slow_off <= wr_cfg.slow_off;
                cfg_q.mon_en   <= wr_cfg.mon_en;
                cfg_q.src_sel  <= wr_cfg.src_sel;
                if (!cfg_q.src_sel) begin
                    cfg_q.ext_sel <= wr_cfg.ext_sel;
                end
            end
            if (fail) begin
                cfg_q.src_sel <= 1'b0;
            end
        end
    end

    assign cfg_o = cfg_q;

    AST_LOCKED_STABLE: assert property (@(posedge clk) disable iff (rst)
        !take && !fail |=> $stable(cfg_q)); // R7
    AST_FAIL_CLEARS_SRC: assert property (@(posedge clk) disable iff (rst)
        fail |=> !cfg_q.src_sel); // R9
    AST_EXT_GUARDED: assert property (@(posedge clk) disable iff (rst)
        cfg_q.src_sel |=> $stable(cfg_q.ext_sel)); // R8

endmodule

// File: rtl/ckc_ctrl_reg.sv
module ckc_ctrl_reg
    import ckc_pkg::*;
#(
    parameter int WIN_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_stb,
    input  logic       addr_hit,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       mon_fail,
    output logic       unlocked,
    output logic       ext_in_sel,
    output logic       src_sel,
    output logic       mon_en,
    output logic       slow_osc_off,
    output logic [1:0] clk_mode
);
    logic     wr_acc;
    logic     unlock_req;
    logic     cfg_write;
    logic     win_open;
    logic     take;
    ckc_cfg_t cfg;

    assign wr_acc     = wr_stb && addr_hit;
    assign unlock_req = wr_acc && is_unlock(wdata);
    assign cfg_write  = wr_acc && !is_unlock(wdata);
    assign take       = win_open && cfg_write;

    ckc_window #(.WIN_CYCLES(WIN_CYCLES)) u_window (
        .clk        (clk),
        .rst        (rst),
        .unlock_req (unlock_req),
        .close_req  (cfg_write),
        .open_o     (win_open)
    );

    ckc_fields u_fields (
        .clk   (clk),
        .rst   (rst),
        .take  (take),
        .wdata (wdata),
        .fail  (mon_fail),
        .cfg_o (cfg)
    );

    assign rdata        = pack_reg(win_open, cfg);
    assign unlocked     = win_open;
    assign ext_in_sel   = cfg.ext_sel;
    assign src_sel      = cfg.src_sel;
    assign mon_en       = cfg.mon_en;
    assign slow_osc_off = cfg.slow_off;
    assign clk_mode     = cfg.mode;

    AST_OPEN_NEEDS_PATTERN: assert property (@(posedge clk) disable iff (rst)
        $rose(win_open) |-> $past(wr_stb && addr_hit && wdata == 8'h80)); // R3
    AST_RSV_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(wr_acc) |-> rdata[BIT_RSV] == 1'b0); // R1

endmodule

// File: tb/sim_ckc_ctrl_reg.sv
module sim_ckc_ctrl_reg;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 22;

    // {wr, fail, data[7:0], expected rdata[7:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 8'h1F, 8'h00},  // R7 locked write ignored
        {1'b1, 1'b0, 8'h80, 8'h80},  // R3 unlock
        {1'b1, 1'b0, 8'h1B, 8'h1B},  // R5 R8 load, close
        {1'b1, 1'b0, 8'h80, 8'h9B},
        {1'b1, 1'b0, 8'h3B, 8'h1B},  // R8 ext blocked, src=1
        {1'b1, 1'b0, 8'h80, 8'h9B},
        {1'b1, 1'b0, 8'h2C, 8'h0C},  // R8 ext blocked (old src=1)
        {1'b1, 1'b0, 8'h80, 8'h8C},
        {1'b1, 1'b0, 8'h21, 8'h21},  // R8 ext accepted
        {1'b0, 1'b0, 8'h00, 8'h21},
        {1'b1, 1'b0, 8'h81, 8'h21},  // R3 not an unlock pattern
        {1'b1, 1'b0, 8'h80, 8'hA1},
        {1'b0, 1'b0, 8'h00, 8'hA1},
        {1'b1, 1'b0, 8'h80, 8'hA1},  // R6 rewrite no effect
        {1'b0, 1'b0, 8'h00, 8'hA1},
        {1'b0, 1'b0, 8'h00, 8'h21},  // R4 four cycles then clear
        {1'b1, 1'b0, 8'h13, 8'h21},  // R7 locked
        {1'b1, 1'b0, 8'h80, 8'hA1},
        {1'b1, 1'b0, 8'h50, 8'h10},  // R1 bit6 reads zero
        {1'b0, 1'b1, 8'h00, 8'h00},  // R9 fail clears src
        {1'b1, 1'b0, 8'h80, 8'h80},
        {1'b1, 1'b1, 8'h1F, 8'h0F}   // R9 fail beats write
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic       addr_hit = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       mon_fail = 1'b0;
    logic [7:0] rdata;
    logic       unlocked, ext_in_sel, src_sel, mon_en, slow_osc_off;
    logic [1:0] clk_mode;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckc_ctrl_reg u0 (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr_hit(addr_hit),
        .wdata(wdata), .rdata(rdata), .mon_fail(mon_fail),
        .unlocked(unlocked), .ext_in_sel(ext_in_sel), .src_sel(src_sel),
        .mon_en(mon_en), .slow_osc_off(slow_osc_off), .clk_mode(clk_mode)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic hit, input logic [7:0] d, input logic f);
        wr_stb = w; addr_hit = hit; wdata = d; mon_fail = f;
        @(negedge clk);
        wr_stb = 1'b0; addr_hit = 1'b0; wdata = 8'h00; mon_fail = 1'b0;
    endtask

    function automatic logic [7:0] port_word();
        return {unlocked, 1'b0, ext_in_sel, src_sel, mon_en, slow_osc_off, clk_mode};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R2 reset rdata", rdata, 8'h00);
        check("R2 reset fields", port_word(), 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][17], 1'b1, VEC[i][15:8], VEC[i][16]);
            check($sformatf("R1 vector %0d rdata", i), rdata, VEC[i][7:0]);
            check($sformatf("R1 vector %0d fields", i), port_word(), VEC[i][7:0]);
        end

        // R4: write in the last open cycle is accepted
        step(1'b1, 1'b1, 8'h80, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b0);
        check("R4 still open in 4th cycle", rdata, 8'h8F);
        step(1'b1, 1'b1, 8'h03, 1'b0);
        check("R4 last-cycle write", rdata, 8'h03);

        // R7: no address match is ignored, even while unlocked
        step(1'b1, 1'b1, 8'h80, 1'b0);
        step(1'b1, 1'b0, 8'h1C, 1'b0);
        check("R7 addr miss ignored", rdata, 8'h83);

        // R2: reset mid-window
        step(1'b1, 1'b1, 8'h1F, 1'b0);
        check("R8 load before reset", rdata, 8'h1F);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R2 reset after use", rdata, 8'h00);
        check("R2 reset fields after use", port_word(), 8'h00);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule